// File: doc/BRIEF.md
# Destination-Address Packet Steering Filter

This block sits inline in a router's packet datapath and decides, for every frame, which of two outputs it leaves through. It reads the IPv4 destination address out of the frame header as the beats stream past and compares it in a single cycle against every slot of a small rule table built as a content-addressable match array. A frame whose address matches a live slot leaves through the host port, so that slower software can judge it. Every other frame leaves through the forwarding port untouched.

Beats wait in a short FIFO until the address has been seen and compared. The route is therefore known before the first beat of a frame goes out, and a whole frame always takes one port. The rule table can be rewritten at any time through a single-cycle write port, even while traffic flows. A running counter and a one-cycle pulse report each frame that is diverted to the host.

Top module: `ipf_dst_filter`

## Requirements
- R1: Byte 0 of a frame sits in bits [DATA_W-1:DATA_W-8] of its first beat, and later bytes follow at lower bit positions, then on into the next beat. The frame is IPv4 when bytes 12..13 read 0x0800. Its destination address is bytes 30..33, most significant byte first. An IPv4 frame whose address equals the address of a valid table slot leaves on the host port with every beat's data, start flag and end flag unchanged, and nothing of it appears on the forwarding port.
- R2: An IPv4 frame whose address matches no valid slot leaves unchanged on the forwarding port only.
- R3: A frame whose EtherType is not 0x0800 takes the forwarding port, even when bytes 30..33 equal a valid slot's address.
- R4: A frame that ends before the beat holding byte 33 arrives takes the forwarding port. With 64-bit beats, that is any frame of fewer than 5 beats.
- R5: A write with cfg_we high stores cfg_addr and cfg_valid into slot cfg_idx at the next clock edge. A slot whose valid bit is clear never matches.
- R6: When a table write lands in the same cycle as the beat that completes a frame's address, that frame is judged against the table as it stood before the write.
- R7: hit_count starts at zero and rises by exactly one for each frame routed to the host port. Frames routed to the forwarding port leave it unchanged.
- R8: lookup_hit is high for exactly one cycle for each frame judged a match, one cycle after the beat that completed its address was accepted.
- R9: When the selected output holds ready low, that output keeps its valid flag and its beat steady, and the input stalls once the FIFO fills. No beat is lost, duplicated or reordered.
- R10: During and right after reset, both outputs are idle, hit_count is zero, every table slot is invalid, and in_ready is high.
- R11: fwd_valid and host_valid are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Incoming beat |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_valid | input | 1 | Incoming beat present |
| in_ready | output | 1 | Block can take a beat |
| fwd_data | output | DATA_W | Forwarding-port beat |
| fwd_sop | output | 1 | Forwarding-port first beat |
| fwd_eop | output | 1 | Forwarding-port last beat |
| fwd_valid | output | 1 | Forwarding-port beat present |
| fwd_ready | input | 1 | Downstream forwarding logic takes the beat |
| host_data | output | DATA_W | Host-port beat |
| host_sop | output | 1 | Host-port first beat |
| host_eop | output | 1 | Host-port last beat |
| host_valid | output | 1 | Host-port beat present |
| host_ready | input | 1 | Host path takes the beat |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Table slot to write |
| cfg_valid | input | 1 | Valid bit for the written slot |
| cfg_addr | input | 32 | Address for the written slot |
| lookup_hit | output | 1 | One-cycle pulse per matching frame |
| hit_count | output | CNT_W | Frames diverted to the host port |

## Verification
The bench uses the default values: 64-bit beats, 32 table slots and an 8-deep beat FIFO. With 8-byte beats the destination address straddles beats 3 and 4, so capture across a beat boundary is exercised. Short frames of 1 to 4 beats hit the R4 boundary. Slot 31 is used, which reaches the top of the index range. The FIFO depth is only a little above the five beats needed before a decision, so random ready patterns on both outputs press the input stall and the hold-while-not-ready rules.

// File: rtl/ipf_pkg.sv
`timescale 1ns/1ps
package ipf_pkg;

    localparam int ADDR_W     = 32;
    localparam int ET_FIRST   = 12;
    localparam int DST_FIRST  = 30;
    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;

    typedef logic [ADDR_W-1:0] ip_addr_t;

    typedef struct packed {
        logic     valid;
        ip_addr_t addr;
    } rule_t;

    typedef enum logic {
        ROUTE_FWD  = 1'b0,
        ROUTE_HOST = 1'b1
    } route_e;

    // Beat index (from 0) that carries the last destination-address byte.
    function automatic int hdr_last_beat(int bytes_per_beat);
        return (DST_FIRST + 3) / bytes_per_beat;
    endfunction

endpackage

// File: rtl/ipf_fifo.sv
`timescale 1ns/1ps
module ipf_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    output logic             full,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q;

    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);
    assign dout  = mem[rp_q];

    always_ff @(posedge clk) begin
        if (push) mem[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + AW'(1);
            if (pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + AW'(1);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/ipf_hdr_parse.sv
`timescale 1ns/1ps
module ipf_hdr_parse
    import ipf_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_fire,
    input  logic [DATA_W-1:0] data,
    input  logic              eop,
    output logic              decide,
    output logic              is_ipv4,
    output ip_addr_t          dst_addr
);
    localparam int BYTES     = DATA_W / 8;
    localparam int LAST_BEAT = hdr_last_beat(BYTES);
    localparam int CNT_W     = $clog2(LAST_BEAT + 2);

    logic [CNT_W-1:0] beat_q;
    logic             done_q;
    ip_addr_t         dst_q, dst_c;
    logic [15:0]      et_q, et_c;
    logic             last_here;

    // Overlay the bytes of the current beat onto the captured header fields.
    always_comb begin
        dst_c = dst_q;
        et_c  = et_q;
        for (int k = 0; k < BYTES; k++) begin
            int pos;
            pos = int'(beat_q) * BYTES + k;
            if (pos >= DST_FIRST && pos < DST_FIRST + 4)
                dst_c[8*(DST_FIRST+3-pos) +: 8] = data[DATA_W-1-8*k -: 8];
            if (pos >= ET_FIRST && pos < ET_FIRST + 2)
                et_c[8*(ET_FIRST+1-pos) +: 8] = data[DATA_W-1-8*k -: 8];
        end
    end

    assign last_here = (int'(beat_q) == LAST_BEAT);
    assign decide    = beat_fire && !done_q && (last_here || eop);
    assign is_ipv4   = last_here && (et_c == ETYPE_IPV4);
    assign dst_addr  = dst_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            done_q <= 1'b0;
            dst_q  <= '0;
            et_q   <= '0;
        end else if (beat_fire) begin
            if (eop) begin
                beat_q <= '0;
                done_q <= 1'b0;
            end else if (!done_q) begin
                dst_q <= dst_c;
                et_q  <= et_c;
                if (last_here) done_q <= 1'b1;
                else           beat_q <= beat_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/ipf_rule_cam.sv
`timescale 1ns/1ps
module ipf_rule_cam
    import ipf_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  ip_addr_t         wr_addr,
    input  ip_addr_t         key,
    output logic             hit
);
    logic [ENTRIES-1:0] match;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        rule_t slot_q;
        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= '0;
            else if (wr_en && (wr_idx == IDX_W'(e)))
                slot_q <= '{valid: wr_valid, addr: wr_addr};
        end
        assign match[e] = slot_q.valid && (slot_q.addr == key);
    end

    assign hit = |match;
endmodule

// File: rtl/ipf_dst_filter.sv
`timescale 1ns/1ps
module ipf_dst_filter
    import ipf_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int ENTRIES    = 32,
    parameter int IDX_W      = $clog2(ENTRIES),
    parameter int FIFO_DEPTH = 8,
    parameter int CNT_W      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] fwd_data,
    output logic              fwd_sop,
    output logic              fwd_eop,
    output logic              fwd_valid,
    input  logic              fwd_ready,
    output logic [DATA_W-1:0] host_data,
    output logic              host_sop,
    output logic              host_eop,
    output logic              host_valid,
    input  logic              host_ready,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_valid,
    input  logic [31:0]       cfg_addr,
    output logic              lookup_hit,
    output logic [CNT_W-1:0]  hit_count
);
    localparam int BEAT_W = DATA_W + 2;

    logic              in_fire, out_fire;
    logic              decide, is_ipv4, cam_hit, frame_hit;
    ip_addr_t          dst_addr;
    logic              dat_full, dat_empty, dec_full, dec_empty;
    logic [BEAT_W-1:0] dat_din, dat_dout;
    logic [0:0]        dec_din, dec_dout;
    route_e            head_route;
    logic              head_ok, head_sop, head_eop;
    logic [DATA_W-1:0] head_data;
    logic              lookup_hit_q;
    logic [CNT_W-1:0]  hit_cnt_q;

    assign in_ready = !dat_full && !dec_full;
    assign in_fire  = in_valid && in_ready;

    ipf_hdr_parse #(.DATA_W(DATA_W)) u_parse (
        .clk       (clk),
        .rst       (rst),
        .beat_fire (in_fire),
        .data      (in_data),
        .eop       (in_eop),
        .decide    (decide),
        .is_ipv4   (is_ipv4),
        .dst_addr  (dst_addr)
    );

    ipf_rule_cam #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_cam (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_valid (cfg_valid),
        .wr_addr  (cfg_addr),
        .key      (dst_addr),
        .hit      (cam_hit)
    );

    assign frame_hit = is_ipv4 && cam_hit;

    assign dat_din = {in_sop, in_eop, in_data};
    ipf_fifo #(.WIDTH(BEAT_W), .DEPTH(FIFO_DEPTH)) u_beats (
        .clk   (clk),
        .rst   (rst),
        .push  (in_fire),
        .din   (dat_din),
        .full  (dat_full),
        .pop   (out_fire),
        .dout  (dat_dout),
        .empty (dat_empty)
    );

    assign dec_din = frame_hit ? ROUTE_HOST : ROUTE_FWD;
    ipf_fifo #(.WIDTH(1), .DEPTH(FIFO_DEPTH)) u_routes (
        .clk   (clk),
        .rst   (rst),
        .push  (decide),
        .din   (dec_din),
        .full  (dec_full),
        .pop   (out_fire && head_eop),
        .dout  (dec_dout),
        .empty (dec_empty)
    );

    assign {head_sop, head_eop, head_data} = dat_dout;
    assign head_route = route_e'(dec_dout[0]);
    assign head_ok    = !dat_empty && !dec_empty;

    assign fwd_valid  = head_ok && (head_route == ROUTE_FWD);
    assign host_valid = head_ok && (head_route == ROUTE_HOST);
    assign fwd_data   = head_data;
    assign fwd_sop    = head_sop;
    assign fwd_eop    = head_eop;
    assign host_data  = head_data;
    assign host_sop   = head_sop;
    assign host_eop   = head_eop;
    assign out_fire   = (fwd_valid && fwd_ready) || (host_valid && host_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            lookup_hit_q <= 1'b0;
            hit_cnt_q    <= '0;
        end else begin
            lookup_hit_q <= decide && frame_hit;
            if (decide && frame_hit) hit_cnt_q <= hit_cnt_q + CNT_W'(1);
        end
    end

    assign lookup_hit = lookup_hit_q;
    assign hit_count  = hit_cnt_q;
endmodule

// File: rtl/ipf_dst_filter_chk.sv
`timescale 1ns/1ps
module ipf_dst_filter_chk #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic [DATA_W-1:0] fwd_data,
    input logic              fwd_sop,
    input logic              fwd_eop,
    input logic              fwd_valid,
    input logic              fwd_ready,
    input logic [DATA_W-1:0] host_data,
    input logic              host_sop,
    input logic              host_eop,
    input logic              host_valid,
    input logic              host_ready,
    input logic              lookup_hit,
    input logic [CNT_W-1:0]  hit_count
);
    a_r11_one_port: assert property (@(posedge clk) disable iff (rst)
        !(fwd_valid && host_valid));

    a_r9_fwd_hold: assert property (@(posedge clk) disable iff (rst)
        (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_data)
                                       && $stable(fwd_sop) && $stable(fwd_eop)));

    a_r9_host_hold: assert property (@(posedge clk) disable iff (rst)
        (host_valid && !host_ready) |=> (host_valid && $stable(host_data)
                                         && $stable(host_sop) && $stable(host_eop)));

    a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
        hit_count == $past(hit_count) + CNT_W'(lookup_hit));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        lookup_hit |=> !lookup_hit);

    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> (!fwd_valid && !host_valid && in_ready && hit_count == '0));
endmodule

bind ipf_dst_filter ipf_dst_filter_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_ready   (in_ready),
    .fwd_data   (fwd_data),
    .fwd_sop    (fwd_sop),
    .fwd_eop    (fwd_eop),
    .fwd_valid  (fwd_valid),
    .fwd_ready  (fwd_ready),
    .host_data  (host_data),
    .host_sop   (host_sop),
    .host_eop   (host_eop),
    .host_valid (host_valid),
    .host_ready (host_ready),
    .lookup_hit (lookup_hit),
    .hit_count  (hit_count)
);

// File: tb/tb_ipf_dst_filter.sv
`timescale 1ns/1ps
module tb_ipf_dst_filter;
    localparam int DW = 64, NE = 32, IW = 5, FD = 8, CW = 32, BYTES = DW / 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1;
    logic [DW-1:0] in_data = '0;
    logic in_sop = 0, in_eop = 0, in_valid = 0, in_ready;
    logic [DW-1:0] fwd_data, host_data;
    logic fwd_sop, fwd_eop, fwd_valid, host_sop, host_eop, host_valid;
    logic fwd_ready = 1'b1, host_ready = 1'b1;
    logic cfg_we = 0, cfg_valid = 0;
    logic [IW-1:0] cfg_idx = '0;
    logic [31:0] cfg_addr = '0;
    logic lookup_hit;
    logic [CW-1:0] hit_count;

    ipf_dst_filter #(.DATA_W(DW), .ENTRIES(NE), .IDX_W(IW), .FIFO_DEPTH(FD), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_valid(in_valid), .in_ready(in_ready),
        .fwd_data(fwd_data), .fwd_sop(fwd_sop), .fwd_eop(fwd_eop), .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
        .host_data(host_data), .host_sop(host_sop), .host_eop(host_eop), .host_valid(host_valid), .host_ready(host_ready),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_addr(cfg_addr),
        .lookup_hit(lookup_hit), .hit_count(hit_count)
    );

    typedef struct {
        logic [DW-1:0] d;
        logic s;
        logic e;
        string tag;
    } exp_t;

    exp_t fq[$];
    exp_t hq[$];
    logic        mvalid [NE];
    logic [31:0] maddr  [NE];
    int tests = 0, fails = 0, exp_hits = 0, pulses = 0;
    bit bp_on = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pop_cmp(inout exp_t q[$], input logic [DW-1:0] d, input logic s, input logic e, input string port);
        exp_t x;
        if (q.size() == 0) begin
            tests++; fails++;
            $display("FAIL R9 unexpected beat on %s actual=%0h expected=none", port, d);
        end else begin
            x = q.pop_front();
            check(d == x.d && s == x.s && e == x.e, {x.tag, " ", port},
                  longint'(d), longint'(x.d));
        end
    endtask

    // Output monitor: set ready for this cycle, then record the handshake at the next edge.
    always @(negedge clk) begin
        if (!rst) begin
            fwd_ready  = bp_on ? ($urandom % 3 != 0) : 1'b1;
            host_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
            if (fwd_valid && host_valid) check(0, "R11 both valid", 1, 0);
            if (fwd_valid && fwd_ready)   pop_cmp(fq, fwd_data, fwd_sop, fwd_eop, "fwd");
            if (host_valid && host_ready) pop_cmp(hq, host_data, host_sop, host_eop, "host");
            if (lookup_hit) pulses++;
        end
    end

    task automatic cfg_write(input int idx, input logic v, input logic [31:0] a);
        @(negedge clk);
        cfg_we = 1; cfg_idx = IW'(idx); cfg_valid = v; cfg_addr = a;
        @(negedge clk);
        cfg_we = 0;
        mvalid[idx] = v; maddr[idx] = a;
    endtask

    task automatic send_pkt(input logic [31:0] dst, input logic [15:0] et, input int nb,
                            input int wr_beat, input int wr_idx, input logic wr_v,
                            input logic [31:0] wr_a, input string tag);
        logic [DW-1:0] beats[$];
        bit hit;
        exp_t x;
        for (int b = 0; b < nb; b++) begin
            logic [DW-1:0] w;
            w = '0;
            for (int k = 0; k < BYTES; k++) begin
                int pos;
                logic [7:0] by;
                pos = b * BYTES + k;
                by = 8'(pos * 13 + nb);
                if (pos == 12) by = et[15:8];
                if (pos == 13) by = et[7:0];
                if (pos >= 30 && pos <= 33) by = dst[8*(33-pos) +: 8];
                w[DW-1-8*k -: 8] = by;
            end
            beats.push_back(w);
        end
        hit = 0;
        if (nb * BYTES >= 34 && et == 16'h0800)
            for (int e = 0; e < NE; e++) if (mvalid[e] && maddr[e] == dst) hit = 1;
        if (hit) exp_hits++;
        for (int b = 0; b < nb; b++) begin
            x.d = beats[b]; x.s = (b == 0); x.e = (b == nb - 1); x.tag = tag;
            if (hit) hq.push_back(x); else fq.push_back(x);
        end
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            in_valid = 1; in_data = beats[b]; in_sop = (b == 0); in_eop = (b == nb - 1);
            cfg_we = (b == wr_beat); cfg_idx = IW'(wr_idx); cfg_valid = wr_v; cfg_addr = wr_a;
            while (!in_ready) @(negedge clk);
            if (b == wr_beat) begin mvalid[wr_idx] = wr_v; maddr[wr_idx] = wr_a; end
        end
        @(negedge clk);
        in_valid = 0; cfg_we = 0;
    endtask

    task automatic drain();
        while (fq.size() != 0 || hq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    function automatic logic [31:0] rule_addr(input int e);
        return 32'hC0A8_0008 + 32'(e) * 32'h100;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R9 watchdog expired actual=hung expected=finished");
            report();
        end
    end

    initial begin
        for (int e = 0; e < NE; e++) begin mvalid[e] = 0; maddr[e] = '0; end
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10: idle state after reset
        check(!fwd_valid && !host_valid, "R10 outputs idle", {fwd_valid, host_valid}, 0);
        check(hit_count == 0, "R10 count zero", hit_count, 0);
        check(in_ready == 1, "R10 ready", in_ready, 1);
        // R10: table empty, so a frame to any later rule address is forwarded
        send_pkt(rule_addr(0), 16'h0800, 6, -1, 0, 0, 0, "R10");
        drain();

        // R5: program every slot
        for (int e = 0; e < NE; e++) cfg_write(e, 1'b1, rule_addr(e));

        send_pkt(rule_addr(0), 16'h0800, 8, -1, 0, 0, 0, "R1");
        send_pkt(rule_addr(31), 16'h0800, 5, -1, 0, 0, 0, "R1");
        send_pkt(32'h0A01_0203, 16'h0800, 7, -1, 0, 0, 0, "R2");
        send_pkt(rule_addr(4), 16'h86DD, 6, -1, 0, 0, 0, "R3");
        send_pkt(rule_addr(5), 16'h0800, 4, -1, 0, 0, 0, "R4");
        send_pkt(rule_addr(5), 16'h0800, 1, -1, 0, 0, 0, "R4");
        drain();
        check(hit_count == CW'(exp_hits), "R7 count after first set", hit_count, exp_hits);

        // R5: a cleared slot never matches
        cfg_write(3, 1'b0, rule_addr(3));
        send_pkt(rule_addr(3), 16'h0800, 6, -1, 0, 0, 0, "R5");
        drain();

        // R6: write lands with the deciding beat (index 4)
        send_pkt(rule_addr(7), 16'h0800, 6, 4, 7, 1'b0, rule_addr(7), "R6");
        drain();
        send_pkt(32'h0B0B_0B0B, 16'h0800, 6, 4, 9, 1'b1, 32'h0B0B_0B0B, "R6");
        drain();
        send_pkt(32'h0B0B_0B0B, 16'h0800, 6, -1, 0, 0, 0, "R5");
        drain();

        // R9: random backpressure on both ports
        bp_on = 1;
        for (int p = 0; p < 30; p++) begin
            int nb, sel;
            logic [31:0] a;
            nb  = 1 + ($urandom % 10);
            sel = $urandom % 4;
            a   = (sel == 0) ? 32'h0C00_0000 + 32'(p) : rule_addr(10 + ($urandom % 22));
            send_pkt(a, (sel == 1) ? 16'h0806 : 16'h0800, nb, -1, 0, 0, 0, "R9");
        end
        repeat (20) @(negedge clk);
        bp_on = 0;
        drain();

        check(fq.size() == 0 && hq.size() == 0, "R9 all beats delivered", fq.size() + hq.size(), 0);
        check(hit_count == CW'(exp_hits), "R7 final count", hit_count, exp_hits);
        check(pulses == exp_hits, "R8 pulse count", pulses, exp_hits);
        done = 1;
        report();
    end
endmodule